// File: doc/BRIEF.md
# Coarse/Fine Phase Comparator with Lock Indicator

This block compares two pulse streams inside a frequency synthesiser loop: the divided reference and the divided oscillator ("main") output. Each stream arrives as one-cycle edge pulses in the system clock domain. A coarse phase/frequency detector measures how many clock cycles separate each reference edge from its partner main edge. Until the loop settles, it drives a pump-up or pump-down request. The request is modelled as a three-state output: `pump_up` and `pump_dn` carry the level, and `pump_oe` is the enable.

After two consecutive measurements inside a programmable window, the coarse output releases to high impedance (`pump_oe` low) and the active-low lock flag `lock_n` drops. Every completed measurement also updates a fine error word. A ramp starts at mid-scale on the leading edge and runs up when the reference leads or down when the main edge leads. The ramp is captured when the trailing edge arrives, once per reference period. When the loop is locked and aligned, the word sits at mid-scale, and its offset from mid-scale equals the phase error in cycles.

The coarse state machine has three states. `CP_IDLE` waits for the next edge. `CP_REF_LEAD` is entered from `CP_IDLE` on a lone reference edge. `CP_MAIN_LEAD` is entered from `CP_IDLE` on a lone main edge. Both lead states return to `CP_IDLE` on the partner edge. A repeated leading edge keeps the current lead state, and the error keeps growing. When both edges arrive together in `CP_IDLE`, the state stays in `CP_IDLE` and the error is zero.

The lock state machine has three states. `LK_SEEK` moves to `LK_QUALIFY` on an in-window measurement. `LK_QUALIFY` moves to `LK_LOCKED` on a second in-window measurement. It returns to `LK_SEEK` on an out-of-window measurement or an overrun. `LK_LOCKED` returns to `LK_SEEK` on an overrun. An overrun is the cycle in which a pending error reaches the window size without a partner edge.

Top module: `phase_cmp_lock`

## Requirements
- R1: While `rst_n` is low, outputs are `pump_up`=0, `pump_dn`=0, `pump_oe`=1, `lock_n`=1, `fine_err`=128 and `fine_vld`=0.
- R2: When unlocked and a reference edge leads the main edge by d cycles, `pump_up` is high for exactly d cycles. It starts in the cycle after the reference edge is sampled, and `pump_dn` stays low.
- R3: When unlocked and a main edge leads the reference edge by d cycles, `pump_dn` is high for exactly d cycles. It starts in the cycle after the main edge is sampled, and `pump_up` stays low.
- R4: `pump_up` and `pump_dn` are never high together. Between measurements, with no edge pending, both are low.
- R5: In the cycle after the trailing edge is sampled, `fine_vld` pulses high for one cycle and `fine_err` is updated. The value is 128+d when the reference led (capped at 255), 128-d when the main edge led (floored at 0), and 128 for coincident edges. `fine_err` holds its value at all other times.
- R6: After two consecutive completed measurements with d ≤ WIN (default 4), `lock_n` and `pump_oe` are low, starting in the cycle after the second trailing edge.
- R7: While `lock_n` is low, `pump_oe`, `pump_up` and `pump_dn` are all low.
- R8: While locked, a pending error that reaches WIN cycles without its partner edge raises `lock_n` and `pump_oe` in the next cycle. From then on, the pump for the leading side drives until the trailing edge arrives.
- R9: A measurement with d > WIN clears the qualification. Two further in-window measurements are needed before lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse per divided reference edge |
| main_edge | input | 1 | One-cycle pulse per divided main (oscillator) edge |
| pump_up | output | 1 | Coarse request to raise frequency |
| pump_dn | output | 1 | Coarse request to lower frequency |
| pump_oe | output | 1 | Coarse output enable; low means high impedance |
| lock_n | output | 1 | Active-low lock indicator |
| fine_err | output | FINE_W | Sampled fine error, mid-scale at zero error |
| fine_vld | output | 1 | One-cycle strobe when `fine_err` is updated |

## Verification
The hardest situation to reach is losing lock partway through a pending measurement. The loop must first be qualified by two in-window pairs, and then a pair must arrive whose gap exceeds the window. Directed sequences walk through this path. They also cover the case where an out-of-window pair falls between two good pairs, and gaps large enough to drive the fine word into saturation at both ends. After the directed sequences, seeded random gaps and directions are applied. These are weighted towards values near the window edge, so that lock is gained and lost repeatedly.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_REF_LEAD,
        CP_MAIN_LEAD
    } cp_state_e;

    typedef enum logic [1:0] {
        LK_SEEK,
        LK_QUALIFY,
        LK_LOCKED
    } lk_state_e;

endpackage

// File: rtl/pcl_coarse_fsm.sv
module pcl_coarse_fsm
    import pcl_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int GAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic             main_edge,
    output cp_state_e        state,
    output logic             done,
    output logic [GAP_W-1:0] done_gap,
    output logic             overrun
);

    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};
    localparam logic [GAP_W-1:0] GAP_WIN = GAP_W'(WIN);

    cp_state_e        state_nxt;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] gap_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CP_IDLE;
            gap_q <= '0;
        end else begin
            state <= state_nxt;
            gap_q <= gap_nxt;
        end
    end

    // transitions and measurement outputs
    always_comb begin
        state_nxt = state;
        gap_nxt   = gap_q;
        done      = 1'b0;
        unique case (state)
            CP_IDLE: begin
                if (ref_edge && main_edge) begin
                    done = 1'b1;
                end else if (ref_edge) begin
                    state_nxt = CP_REF_LEAD;
                    gap_nxt   = GAP_W'(1);
                end else if (main_edge) begin
                    state_nxt = CP_MAIN_LEAD;
                    gap_nxt   = GAP_W'(1);
                end
            end
            CP_REF_LEAD: begin
                if (main_edge) begin
                    done      = 1'b1;
                    state_nxt = CP_IDLE;
                    gap_nxt   = '0;
                end else if (gap_q != GAP_MAX) begin
                    gap_nxt = gap_q + 1'b1;
                end
            end
            CP_MAIN_LEAD: begin
                if (ref_edge) begin
                    done      = 1'b1;
                    state_nxt = CP_IDLE;
                    gap_nxt   = '0;
                end else if (gap_q != GAP_MAX) begin
                    gap_nxt = gap_q + 1'b1;
                end
            end
            default: begin
                state_nxt = CP_IDLE;
                gap_nxt   = '0;
            end
        endcase
        done_gap = (state == CP_IDLE) ? '0 : gap_q;
        overrun  = (state != CP_IDLE) && !done && (gap_q == GAP_WIN);
    end

endmodule

// File: rtl/pcl_fine_ramp.sv
module pcl_fine_ramp
    import pcl_pkg::*;
#(
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cp_state_e         state,
    input  logic              ref_edge,
    input  logic              main_edge,
    input  logic              done,
    output logic [FINE_W-1:0] fine_err,
    output logic              fine_vld
);

    localparam logic [FINE_W-1:0] MID  = FINE_W'(1) << (FINE_W - 1);
    localparam logic [FINE_W-1:0] FMAX = {FINE_W{1'b1}};

    logic [FINE_W-1:0] ramp_q;
    logic [FINE_W-1:0] ramp_nxt;

    always_comb begin
        ramp_nxt = ramp_q;
        unique case (state)
            CP_IDLE: begin
                if (ref_edge && !main_edge)      ramp_nxt = MID + 1'b1;
                else if (main_edge && !ref_edge) ramp_nxt = MID - 1'b1;
                else                             ramp_nxt = MID;
            end
            CP_REF_LEAD:  if (ramp_q != FMAX) ramp_nxt = ramp_q + 1'b1;
            CP_MAIN_LEAD: if (ramp_q != '0)   ramp_nxt = ramp_q - 1'b1;
            default:      ramp_nxt = MID;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q   <= MID;
            fine_err <= MID;
            fine_vld <= 1'b0;
        end else begin
            ramp_q   <= ramp_nxt;
            fine_vld <= done;
            if (done) fine_err <= (state == CP_IDLE) ? MID : ramp_q;
        end
    end

endmodule

// File: rtl/pcl_lock_fsm.sv
module pcl_lock_fsm
    import pcl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic in_win,
    input  logic overrun,
    output logic locked
);

    lk_state_e lk_q;
    lk_state_e lk_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_SEEK;
        else        lk_q <= lk_nxt;
    end

    always_comb begin
        lk_nxt = lk_q;
        unique case (lk_q)
            LK_SEEK:
                if (done && in_win) lk_nxt = LK_QUALIFY;
            LK_QUALIFY:
                if (overrun || (done && !in_win)) lk_nxt = LK_SEEK;
                else if (done && in_win)          lk_nxt = LK_LOCKED;
            LK_LOCKED:
                if (overrun || (done && !in_win)) lk_nxt = LK_SEEK;
            default: lk_nxt = LK_SEEK;
        endcase
    end

    always_comb locked = (lk_q == LK_LOCKED);

endmodule

// File: rtl/phase_cmp_lock.sv
module phase_cmp_lock
    import pcl_pkg::*;
#(
    parameter int WIN    = 4,
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_edge,
    input  logic              main_edge,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              pump_oe,
    output logic              lock_n,
    output logic [FINE_W-1:0] fine_err,
    output logic              fine_vld
);

    localparam int GAP_W = $clog2(WIN + 2);

    cp_state_e        cp_state;
    logic             meas_done;
    logic [GAP_W-1:0] meas_gap;
    logic             meas_over;
    logic             locked;
    logic             in_win;

    pcl_coarse_fsm #(.WIN(WIN), .GAP_W(GAP_W)) u_coarse (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_edge (ref_edge),
        .main_edge(main_edge),
        .state    (cp_state),
        .done     (meas_done),
        .done_gap (meas_gap),
        .overrun  (meas_over)
    );

    pcl_fine_ramp #(.FINE_W(FINE_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (cp_state),
        .ref_edge (ref_edge),
        .main_edge(main_edge),
        .done     (meas_done),
        .fine_err (fine_err),
        .fine_vld (fine_vld)
    );

    always_comb in_win = (meas_gap <= GAP_W'(WIN));

    pcl_lock_fsm u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (meas_done),
        .in_win (in_win),
        .overrun(meas_over),
        .locked (locked)
    );

    // coarse three-state output: enable drops with lock
    always_comb begin
        pump_up = (cp_state == CP_REF_LEAD)  && !locked;
        pump_dn = (cp_state == CP_MAIN_LEAD) && !locked;
        pump_oe = !locked;
        lock_n  = !locked;
    end

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
    parameter int WIN    = 4,
    parameter int FINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pump_up,
    input logic              pump_dn,
    input logic              pump_oe,
    input logic              lock_n,
    input logic [FINE_W-1:0] fine_err,
    input logic              fine_vld
);

    localparam int MID = 1 << (FINE_W - 1);

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n |-> (!pump_oe && !pump_up && !pump_dn));

    p_lock_meas_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> (fine_vld && int'(fine_err) >= MID - WIN
                           && int'(fine_err) <= MID + WIN));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fine_vld |-> $stable(fine_err));

    p_up_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_up) |-> (fine_vld && int'(fine_err) > MID));

    p_dn_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_dn) |-> (fine_vld && int'(fine_err) < MID));

endmodule

bind phase_cmp_lock pcl_checker #(.WIN(WIN), .FINE_W(FINE_W)) u_pcl_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pump_up (pump_up),
    .pump_dn (pump_dn),
    .pump_oe (pump_oe),
    .lock_n  (lock_n),
    .fine_err(fine_err),
    .fine_vld(fine_vld)
);

// File: tb/phase_cmp_lock_tb_top.sv
module phase_cmp_lock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 4;
    localparam int FINE_W     = 8;
    localparam int MID        = 128;
    localparam int FMAX       = 255;

    logic clk = 1'b0;
    logic rst_n;
    logic ref_edge, main_edge;
    logic pump_up, pump_dn, pump_oe, lock_n, fine_vld;
    logic [FINE_W-1:0] fine_err;

    int  n_vec = 0;
    int  n_bad = 0;
    int  exp_good = 0;
    bit  exp_locked = 1'b0;

    phase_cmp_lock #(.WIN(WIN), .FINE_W(FINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .main_edge(main_edge),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
        .lock_n(lock_n), .fine_err(fine_err), .fine_vld(fine_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic int exp_fine(input int d, input bit rf);
        int v;
        if (d == 0) return MID;
        v = rf ? MID + d : MID - d;
        if (v > FMAX) v = FMAX;
        if (v < 0) v = 0;
        return v;
    endfunction

    task automatic check_idle();
        chk(pump_up == 1'b0, "R4 idle up", int'(pump_up), 0);
        chk(pump_dn == 1'b0, "R4 idle dn", int'(pump_dn), 0);
        chk(pump_oe == !exp_locked, "R7 idle oe", int'(pump_oe), int'(!exp_locked));
        chk(lock_n == !exp_locked, "R6 idle lock_n", int'(lock_n), int'(!exp_locked));
        chk(fine_vld == 1'b0, "R5 idle vld", int'(fine_vld), 0);
    endtask

    // one measurement: leading edge, then trailing edge d cycles later
    task automatic run_pair(input int d, input bit rf);
        bit lk;
        int prev_fine;
        prev_fine = int'(fine_err);
        @(negedge clk);
        if (d == 0) begin ref_edge = 1'b1; main_edge = 1'b1; end
        else if (rf) ref_edge = 1'b1;
        else main_edge = 1'b1;
        for (int j = 0; j < d; j++) begin
            @(negedge clk);
            ref_edge = 1'b0; main_edge = 1'b0;
            lk = exp_locked && (j < WIN);
            chk(pump_up == (rf && !lk), (rf ? "R2 up" : "R3 up"), int'(pump_up), int'(rf && !lk));
            chk(pump_dn == (!rf && !lk), (rf ? "R2 dn" : "R3 dn"), int'(pump_dn), int'(!rf && !lk));
            chk(lock_n == !lk, (exp_locked ? "R8 lock_n" : "R7 lock_n"), int'(lock_n), int'(!lk));
            chk(pump_oe == !lk, (exp_locked ? "R8 oe" : "R7 oe"), int'(pump_oe), int'(!lk));
            chk(int'(fine_err) == prev_fine, "R5 hold", int'(fine_err), prev_fine);
            if (j == d - 1) begin
                if (rf) main_edge = 1'b1;
                else    ref_edge  = 1'b1;
            end
        end
        @(negedge clk);
        ref_edge = 1'b0; main_edge = 1'b0;
        chk(fine_vld == 1'b1, "R5 vld", int'(fine_vld), 1);
        chk(int'(fine_err) == exp_fine(d, rf), "R5 value", int'(fine_err), exp_fine(d, rf));
        if (d <= WIN) exp_good = (exp_good >= 2) ? 2 : exp_good + 1;
        else          exp_good = 0;
        exp_locked = (exp_good >= 2);
        chk(lock_n == !exp_locked, (d > WIN ? "R9 lock_n" : "R6 lock_n"), int'(lock_n), int'(!exp_locked));
        chk(pump_oe == !exp_locked, "R6 oe", int'(pump_oe), int'(!exp_locked));
        chk(!pump_up && !pump_dn, "R4 after", int'({pump_up, pump_dn}), 0);
        @(negedge clk);
        check_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ref_edge = 1'b0; main_edge = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values
        chk(pump_up == 1'b0, "R1 up", int'(pump_up), 0);
        chk(pump_dn == 1'b0, "R1 dn", int'(pump_dn), 0);
        chk(pump_oe == 1'b1, "R1 oe", int'(pump_oe), 1);
        chk(lock_n == 1'b1, "R1 lock_n", int'(lock_n), 1);
        chk(int'(fine_err) == MID, "R1 fine", int'(fine_err), MID);
        chk(fine_vld == 1'b0, "R1 vld", int'(fine_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle();

        // R2/R3/R6: unlocked pumps, then lock on two in-window pairs
        run_pair(6, 1'b1);
        run_pair(5, 1'b0);
        run_pair(0, 1'b1);
        run_pair(2, 1'b1);
        // R7: locked, pumps quiet for in-window errors
        run_pair(3, 1'b0);
        run_pair(WIN, 1'b1);
        // R8: lock lost mid-measurement
        run_pair(WIN + 3, 1'b1);
        // R9: bad pair in the middle of qualification
        run_pair(1, 1'b1);
        run_pair(WIN + 5, 1'b0);
        run_pair(1, 1'b1);
        run_pair(1, 1'b0);
        run_pair(WIN + 1, 1'b0);
        // R5 saturation at both ends
        run_pair(130, 1'b1);
        run_pair(130, 1'b0);

        for (int k = 0; k < 400; k++) begin
            int d;
            bit rf;
            if (($urandom % 8) == 0) d = $urandom % 200;
            else                     d = $urandom % (WIN + 4);
            rf = 1'($urandom % 2);
            run_pair(d, rf);
            repeat ($urandom % 3) begin
                @(negedge clk);
                check_idle();
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule